// File: doc/BRIEF.md
# Multi-Mode Programmable Lookup Cell

This block is a small programmable logic cell built around a 16-bit storage word and a four-bit select. The same word serves three purposes chosen by a two-bit mode input. As a truth table, the select picks one stored bit and drives it onto the output, so the cell computes any function of four variables. As a serial delay line, each enabled clock pushes a new data bit into the low end while the select taps any stage. As a 16x1 memory, an enabled clock writes the data bit at the selected location, and the read is combinational.

The word is preloaded through a serial configuration port. While the configuration enable is high, one bit enters per clock, most significant bit first. The top stage is always visible on the scan output, so many cells can be chained into one long configuration path. Loading wins over any data-path update in the same clock.

Top module: `lut_cell`

## Requirements
- R1: A synchronous active-high reset clears all 16 stored bits, so the output reads 0 at every select value and the scan output is 0.
- R2: With the configuration enable high, each clock shifts the word one place toward bit 15 and puts the scan input into bit 0; after 16 such clocks with bits presented in the order b15 down to b0, stored bit i equals bi.
- R3: The scan output always shows stored bit 15, so a word loaded earlier leaves the cell on the scan output, most significant bit first, while the next word is scanned in.
- R4: The output is the stored bit whose index equals the four-bit select (select value k reads bit k), combinationally, in every mode.
- R5: In logic mode (mode 00) the write/shift enable leaves the stored word unchanged.
- R6: In shift mode (mode 01), with the configuration enable low, a clock with the write/shift enable high moves every bit one place toward bit 15 and loads the data input into bit 0.
- R7: In memory mode (mode 10), with the configuration enable low, a clock with the write/shift enable high stores the data input at the selected bit and leaves the other 15 bits unchanged.
- R8: When the configuration enable and the write/shift enable are both high, only the configuration shift takes place, whatever the mode.
- R9: Mode 11 behaves exactly as logic mode: the write/shift enable has no effect on the stored word.
- R10: With both enables low the stored word holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration scan enable |
| cfg_din | input | 1 | Configuration serial data in |
| cfg_dout | output | 1 | Configuration serial data out (stored bit 15) |
| mode | input | 2 | 00 logic, 01 shift, 10 memory, 11 logic |
| sel | input | 4 | Read/write select |
| din | input | 1 | Data input for shift or memory write |
| we | input | 1 | Write/shift enable |
| dout | output | 1 | Selected stored bit |

## Verification
The bench aims at the collisions between the update paths: configuration and write enables raised together in shift and memory modes, where a design with the wrong priority would write or shift data bits into a half-loaded word. It also drives the write enable in modes 00 and 11, where a cell that decoded 11 as memory or let logic mode write would corrupt its truth table. Back-to-back loads check the scan-out order, which a reversed chain would present least significant bit first, and a dense random phase with a reference word catches off-by-one shift direction and wrong write addressing through reads at every select value.

// File: rtl/lut_cell_pkg.sv
`timescale 1ns/1ps
package lut_cell_pkg;

    localparam int SEL_W = 4;

    typedef enum logic [1:0] {
        MODE_LOGIC = 2'b00,
        MODE_SHIFT = 2'b01,
        MODE_RAM   = 2'b10,
        MODE_ALT   = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        OP_TABLE,
        OP_DELAY,
        OP_MEMORY
    } op_e;

    // Collapse the raw mode field onto the operation the store performs.
    function automatic op_e decode_mode(input logic [1:0] raw);
        case (raw)
            MODE_SHIFT: return OP_DELAY;
            MODE_RAM:   return OP_MEMORY;
            default:    return OP_TABLE;
        endcase
    endfunction

endpackage

// File: rtl/lut_cell_store.sv
`timescale 1ns/1ps
module lut_cell_store
    import lut_cell_pkg::*;
#(
    parameter int SEL_BITS = SEL_W,
    localparam int DEPTH = 1 << SEL_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_en,
    input  logic                cfg_din,
    input  op_e                 op,
    input  logic [SEL_BITS-1:0] sel,
    input  logic                din,
    input  logic                we,
    output logic [DEPTH-1:0]    word_q
);

    logic [DEPTH-1:0] word_d;

    always_comb begin
        word_d = word_q;
        if (cfg_en) begin
            word_d = {word_q[DEPTH-2:0], cfg_din};
        end else if (we) begin
            case (op)
                OP_DELAY:  word_d = {word_q[DEPTH-2:0], din};
                OP_MEMORY: word_d[sel] = din;
                default:   word_d = word_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

endmodule

// File: rtl/lut_cell_mux.sv
`timescale 1ns/1ps
module lut_cell_mux #(
    parameter int SEL_BITS = 4,
    localparam int DEPTH = 1 << SEL_BITS
) (
    input  logic [DEPTH-1:0]    leaves,
    input  logic [SEL_BITS-1:0] sel,
    output logic                y
);

    // Heap-ordered tree: node 1 is the root, nodes DEPTH..2*DEPTH-1 are leaves.
    logic node [1:2*DEPTH-1];

    for (genvar i = 0; i < DEPTH; i++) begin : g_leaf
        assign node[DEPTH + i] = leaves[i];
    end

    for (genvar d = 0; d < SEL_BITS; d++) begin : g_level
        for (genvar j = 0; j < (1 << d); j++) begin : g_node
            localparam int K = (1 << d) + j;
            assign node[K] = sel[SEL_BITS-1-d] ? node[2*K+1] : node[2*K];
        end
    end

    assign y = node[1];

endmodule

// File: rtl/lut_cell.sv
`timescale 1ns/1ps
module lut_cell
    import lut_cell_pkg::*;
#(
    parameter int SEL_BITS = SEL_W,
    localparam int DEPTH = 1 << SEL_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_en,
    input  logic                cfg_din,
    output logic                cfg_dout,
    input  logic [1:0]          mode,
    input  logic [SEL_BITS-1:0] sel,
    input  logic                din,
    input  logic                we,
    output logic                dout
);

    op_e              op;
    logic [DEPTH-1:0] word_q;

    assign op = decode_mode(mode);

    lut_cell_store #(.SEL_BITS(SEL_BITS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .cfg_en  (cfg_en),
        .cfg_din (cfg_din),
        .op      (op),
        .sel     (sel),
        .din     (din),
        .we      (we),
        .word_q  (word_q)
    );

    lut_cell_mux #(.SEL_BITS(SEL_BITS)) u_mux (
        .leaves (word_q),
        .sel    (sel),
        .y      (dout)
    );

    assign cfg_dout = word_q[DEPTH-1];

    always_comb begin
        if (!$isunknown({word_q, sel})) begin
            AST_READ_PATH: assert (dout == word_q[sel]); // R4
        end
    end

    AST_CFG_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> (cfg_dout == $past(word_q[DEPTH-2]))); // R3

    AST_CFG_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && we) |=> (word_q[0] == $past(cfg_din))); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !we) |=> $stable(word_q)); // R10

    AST_TABLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && we && (mode == 2'b00 || mode == 2'b11)) |=> $stable(word_q)); // R5

    AST_DELAY_STEP: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && we && mode == 2'b01) |=>
        (word_q[0] == $past(din) && word_q[DEPTH-1:1] == $past(word_q[DEPTH-2:0]))); // R6

    AST_MEM_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && we && mode == 2'b10) |=> (word_q[$past(sel)] == $past(din))); // R7

    AST_MEM_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && we && mode == 2'b10) |=> ($countones(word_q ^ $past(word_q)) <= 1)); // R7

endmodule

// File: tb/lut_cell_tb.sv
`timescale 1ns/1ps
module lut_cell_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic       cfg_dout;
    logic [1:0] mode = 2'b00;
    logic [3:0] sel = 4'd0;
    logic       din = 1'b0;
    logic       we = 1'b0;
    logic       dout;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [15:0] ref_w = 16'h0;

    always #4 clk = ~clk;

    lut_cell u_dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .cfg_dout(cfg_dout), .mode(mode), .sel(sel), .din(din),
        .we(we), .dout(dout)
    );

    function automatic logic [15:0] model_next(input logic [15:0] w, input logic c_en,
            input logic c_d, input logic [1:0] m, input logic [3:0] s,
            input logic d, input logic w_en);
        logic [15:0] r;
        r = w;
        if (c_en) r = {w[14:0], c_d};
        else if (w_en && m == 2'b01) r = {w[14:0], d};
        else if (w_en && m == 2'b10) r[s] = d;
        return r;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive at negedge, clock once, return at next negedge.
    task automatic step(input logic c_en, input logic c_d, input logic [1:0] m,
            input logic [3:0] s, input logic d, input logic w_en);
        cfg_en = c_en; cfg_din = c_d; mode = m; sel = s; din = d; we = w_en;
        @(posedge clk);
        ref_w = model_next(ref_w, c_en, c_d, m, s, d, w_en);
        @(negedge clk);
        cfg_en = 1'b0; we = 1'b0;
    endtask

    task automatic read_all(input string req);
        for (int k = 0; k < 16; k++) begin
            sel = 4'(k);
            #1;
            chk(req, dout, ref_w[k]);
        end
        chk(req, cfg_dout, ref_w[15]);
    endtask

    task automatic load(input logic [15:0] w, input string req);
        for (int n = 15; n >= 0; n--) begin
            chk(req, cfg_dout, ref_w[15]);
            step(1'b1, w[n], 2'b00, 4'd0, 1'b0, 1'b0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] prev;
        void'($urandom(32'd7351));
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        ref_w = 16'h0;
        read_all("R1 reset");

        // R2 load and bitwise readback
        load(16'hA5C3, "R2 load");
        chk("R2 word", dout, 1'b1);
        read_all("R2 readback");

        // R3 daisy chain: previous word leaves MSB first
        prev = ref_w;
        for (int n = 15; n >= 0; n--) begin
            chk("R3 scan out", cfg_dout, prev[n]);
            step(1'b1, n[0], 2'b00, 4'd0, 1'b0, 1'b0);
        end
        read_all("R3 second word");

        // R4 function of four variables: 4-input AND then XOR table
        load(16'h8000, "R4 load");
        for (int k = 0; k < 16; k++) begin
            sel = 4'(k); #1;
            chk("R4 and table", dout, k == 15);
        end
        load(16'h6996, "R4 load");
        read_all("R4 xor table");

        // R5 logic mode ignores writes
        step(1'b0, 1'b0, 2'b00, 4'd3, 1'b1, 1'b1);
        step(1'b0, 1'b0, 2'b00, 4'd0, 1'b0, 1'b1);
        read_all("R5 logic no write");

        // R9 mode 11 ignores writes
        step(1'b0, 1'b0, 2'b11, 4'd0, 1'b1, 1'b1);
        step(1'b0, 1'b0, 2'b11, 4'd9, 1'b0, 1'b1);
        read_all("R9 mode 11");

        // R6 shift: walk a single one through all stages
        load(16'h0000, "R6 clear");
        step(1'b0, 1'b0, 2'b01, 4'd0, 1'b1, 1'b1);
        for (int n = 1; n < 16; n++) begin
            sel = 4'(n - 1); #1;
            chk("R6 tap", dout, 1'b1);
            step(1'b0, 1'b0, 2'b01, 4'(n), 1'b0, 1'b1);
        end
        chk("R6 end stage", cfg_dout, 1'b1);
        read_all("R6 shifted");

        // R7 memory writes at both ends and the middle
        step(1'b0, 1'b0, 2'b10, 4'd15, 1'b0, 1'b1);
        step(1'b0, 1'b0, 2'b10, 4'd0, 1'b1, 1'b1);
        step(1'b0, 1'b0, 2'b10, 4'd7, 1'b1, 1'b1);
        read_all("R7 ram");

        // R8 config priority in shift and memory modes
        step(1'b1, 1'b0, 2'b01, 4'd2, 1'b1, 1'b1);
        step(1'b1, 1'b1, 2'b10, 4'd5, 1'b0, 1'b1);
        read_all("R8 priority");

        // R10 idle hold
        repeat (4) step(1'b0, 1'b1, 2'b10, 4'd4, 1'b1, 1'b0);
        read_all("R10 hold");

        // Random mix
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] & r[1], r[2], r[4:3], r[8:5], r[9], r[10]);
            sel = r[14:11]; #1;
            chk("R4 random read", dout, ref_w[sel]);
            chk("R3 random scan", cfg_dout, ref_w[15]);
        end

        // R1 reset after activity
        rst = 1'b1;
        @(posedge clk);
        ref_w = 16'h0;
        @(negedge clk);
        rst = 1'b0;
        read_all("R1 reset again");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule